// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block models the bus command interface of a single bank of NOR-style flash memory. It watches write cycles (address, data, strobe) and decodes the multi-cycle command protocol. The supported operations are the four-cycle word program, entry into and exit from a shortened-program mode, an identification mode, and a soft reset command. An accepted program starts an internal engine. The engine stays busy for a fixed number of clocks and then folds the new data into a small on-chip word array. During that time, reads return a status word instead of array data. In identification mode, reads return fixed identifier words and per-sector lock flags.

Command codes are taken from `wdata[7:0]`. The two unlock writes are AAh to word address 555h and then 55h to 2AAh. After those two writes, a third write to 555h selects the operation: A0h for program set-up, 20h for bypass mode, or 90h for identification mode. The array holds 2^ARR_AW words and is indexed by the low ARR_AW address bits. Sectors are 2^SECT_AW words each.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Writing AAh@555h, 55h@2AAh and A0h@555h in sequence, followed by one write carrying the target address and data, starts a program operation. `busy` is high from the clock edge after that fourth write.
- R2: A program operation stores the old word ANDed with the written data, so bits only change from 1 to 0. The array powers up all ones.
- R3: The two unlock writes followed by 20h@555h enter bypass mode. In bypass mode, A0h at any address followed by one address/data write programs a word. This can repeat any number of times without further unlock writes.
- R4: In bypass mode, 90h followed by 00h (any addresses) returns to read mode. After that, an A0h write followed by an address/data write programs nothing.
- R5: While `busy` is high, every write is ignored. It neither changes the array nor advances the command sequence.
- R6: `busy` stays high for exactly PROG_CYC clock cycles. Afterwards, reads return array data again: in read mode after a standard program, or in bypass mode after a bypass program.
- R7: A read issued while busy returns a status word. Bit 7 is the complement of bit 7 of the programmed data. Bits 6 and 2 read 0 on the first status read and alternate on each later one. Bit 5 is 1 exactly when the data tried to turn a stored 0 into 1. All other bits are 0.
- R8: The two unlock writes followed by 90h@555h enter identification mode. In this mode, reads decode address bits [3:0] as follows: 0h gives 0001h; 1h gives 227Eh; 2h gives 0001h if the addressed sector's LOCK_MASK bit is set and 0000h otherwise; 3h gives 0043h when REDUCED_WAIT is 1 and 0042h otherwise; Eh gives DEV_ID2; Fh gives 2200h; any other offset gives 0000h.
- R9: Identification mode is left only by a write of F0h, which returns to read mode. Any other write leaves the mode unchanged.
- R10: A write that breaks the unlock sequence, or an F0h write during it, returns the decoder to read mode without programming.
- R11: Asserting `rst_n` low during a program aborts it at once. `busy` drops and the target word keeps its old value.
- R12: `rdata` is registered. It holds the result of a read strobe from the clock edge that samples `re` high, and it is 0000h after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| we | input | 1 | Write strobe, one write per high cycle |
| re | input | 1 | Read strobe, one read per high cycle |
| addr | input | 12 | Word address for reads and writes |
| wdata | input | 16 | Write data; command code in bits 7:0 |
| rdata | output | 16 | Registered read data, status or identifier word |
| busy | output | 1 | Program operation in progress |

## Verification
A write sampled at edge E0 that completes a program sequence raises `busy` at E0. `busy` falls at E0+PROG_CYC, which is when the array word is replaced. Reads sampled at E1 through E0+PROG_CYC therefore return status. The bench drives strobes on falling edges and samples `rdata` and `busy` on the next falling edge, one register after the sampling edge. It counts the falling edges during which `busy` is seen high and compares that count with PROG_CYC. Array contents are checked through sweeps over every word, with two arithmetic data patterns whose expected AND is computed in the bench.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int DW  = 16;
  localparam int CAW = 12;

  localparam logic [CAW-1:0] ADR_A = 12'h555;
  localparam logic [CAW-1:0] ADR_B = 12'h2AA;

  localparam logic [7:0] C_UNLK_A = 8'hAA;
  localparam logic [7:0] C_UNLK_B = 8'h55;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_BYP    = 8'h20;
  localparam logic [7:0] C_AUTO   = 8'h90;
  localparam logic [7:0] C_RST    = 8'hF0;
  localparam logic [7:0] C_BYPX   = 8'h00;

  typedef enum logic [2:0] {
    ST_READ, ST_U1, ST_U2, ST_PROG, ST_AUTO, ST_BYP, ST_BYP_PROG, ST_BYP_EXIT
  } seq_st_t;

  function automatic logic [DW-1:0] merge_word(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w);
    return old_w & new_w;
  endfunction

  function automatic logic raise_err(input logic [DW-1:0] old_w,
                                     input logic [DW-1:0] new_w);
    return |(new_w & ~old_w);
  endfunction

  function automatic logic [DW-1:0] status_word(input logic d7, input logic tog,
                                                input logic err);
    logic [DW-1:0] w;
    w    = '0;
    w[7] = ~d7;
    w[6] = tog;
    w[5] = err;
    w[2] = tog;
    return w;
  endfunction

  function automatic logic [DW-1:0] id_word(input logic [3:0] off, input logic locked,
                                            input logic reduced, input logic [DW-1:0] dev2);
    case (off)
      4'h0:    return 16'h0001;
      4'h1:    return 16'h227E;
      4'h2:    return locked ? 16'h0001 : 16'h0000;
      4'h3:    return reduced ? 16'h0043 : 16'h0042;
      4'hE:    return dev2;
      4'hF:    return 16'h2200;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_word,
  input  logic [AW-1:0] peek_idx,
  output logic [DW-1:0] peek_word,
  input  logic [AW-1:0] bus_idx,
  output logic [DW-1:0] bus_word
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_word;
  end

  assign peek_word = mem[peek_idx];
  assign bus_word  = mem[bus_idx];
endmodule

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_cmd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic           busy,
  input  logic [CAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic           launch,
  output logic           id_mode,
  output seq_st_t        st
);
  seq_st_t    st_nx;
  logic       wr_ok;
  logic [7:0] cmd;

  assign wr_ok   = we && !busy;
  assign cmd     = wdata[7:0];
  assign launch  = wr_ok && (st == ST_PROG || st == ST_BYP_PROG);
  assign id_mode = (st == ST_AUTO);

  always_comb begin
    st_nx = st;
    if (wr_ok) begin
      case (st)
        ST_READ:     st_nx = (cmd == C_UNLK_A && addr == ADR_A) ? ST_U1 : ST_READ;
        ST_U1:       st_nx = (cmd == C_UNLK_B && addr == ADR_B) ? ST_U2 : ST_READ;
        ST_U2: begin
          st_nx = ST_READ;
          if (addr == ADR_A) begin
            if (cmd == C_PROG)      st_nx = ST_PROG;
            else if (cmd == C_BYP)  st_nx = ST_BYP;
            else if (cmd == C_AUTO) st_nx = ST_AUTO;
          end
        end
        ST_PROG:     st_nx = ST_READ;
        ST_AUTO:     st_nx = (cmd == C_RST) ? ST_READ : ST_AUTO;
        ST_BYP: begin
          if (cmd == C_PROG)      st_nx = ST_BYP_PROG;
          else if (cmd == C_AUTO) st_nx = ST_BYP_EXIT;
        end
        ST_BYP_PROG: st_nx = ST_BYP;
        ST_BYP_EXIT: st_nx = (cmd == C_BYPX) ? ST_READ : ST_BYP;
        default:     st_nx = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_READ;
    else        st <= st_nx;
  end
endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 8,
  parameter int PROG_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [AW-1:0] l_idx,
  input  logic [DW-1:0] l_data,
  input  logic [DW-1:0] old_word,
  input  logic          rd_pulse,
  output logic          busy,
  output logic [AW-1:0] p_idx,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] stat
);
  localparam int CW = $clog2(PROG_CYC + 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] p_data;
  logic          err;
  logic          tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      p_idx  <= '0;
      p_data <= '0;
      err    <= 1'b0;
      tog    <= 1'b0;
    end else if (launch) begin
      busy   <= 1'b1;
      cnt    <= CW'(PROG_CYC - 1);
      p_idx  <= l_idx;
      p_data <= l_data;
      err    <= raise_err(old_word, l_data);
      tog    <= 1'b0;
    end else if (busy) begin
      if (rd_pulse) tog <= ~tog;
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign mem_we    = busy && (cnt == '0);
  assign mem_wdata = merge_word(old_word, p_data);
  assign stat      = status_word(p_data[7], tog, err);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int                               ARR_AW       = 8,
  parameter int                               SECT_AW      = 6,
  parameter int                               PROG_CYC     = 6,
  parameter logic                             REDUCED_WAIT = 1'b1,
  parameter logic [15:0]                      DEV_ID2      = 16'h2222,
  parameter logic [(1<<(ARR_AW-SECT_AW))-1:0] LOCK_MASK    = 'b0101
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        re,
  input  logic [11:0] addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        busy
);
  logic              launch;
  logic              id_mode;
  seq_st_t           st;
  logic [ARR_AW-1:0] p_idx;
  logic [ARR_AW-1:0] peek_idx;
  logic [DW-1:0]     mem_old;
  logic [DW-1:0]     arr_word;
  logic              mem_we;
  logic [DW-1:0]     mem_wdata;
  logic [DW-1:0]     stat;
  logic              rd_busy;
  logic              sect_locked;

  flash_seq_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .we(we), .busy(busy), .addr(addr), .wdata(wdata),
    .launch(launch), .id_mode(id_mode), .st(st)
  );

  assign peek_idx = busy ? p_idx : addr[ARR_AW-1:0];
  assign rd_busy  = re && busy;

  flash_prog_engine #(.AW(ARR_AW), .PROG_CYC(PROG_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .launch(launch), .l_idx(addr[ARR_AW-1:0]),
    .l_data(wdata), .old_word(mem_old), .rd_pulse(rd_busy), .busy(busy),
    .p_idx(p_idx), .mem_we(mem_we), .mem_wdata(mem_wdata), .stat(stat)
  );

  flash_array #(.AW(ARR_AW), .DW(DW)) u_arr (
    .clk(clk), .wr_en(mem_we), .wr_idx(p_idx), .wr_word(mem_wdata),
    .peek_idx(peek_idx), .peek_word(mem_old),
    .bus_idx(addr[ARR_AW-1:0]), .bus_word(arr_word)
  );

  assign sect_locked = LOCK_MASK[addr[ARR_AW-1:SECT_AW]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (re) begin
      if (busy)         rdata <= stat;
      else if (id_mode) rdata <= id_word(addr[3:0], sect_locked, REDUCED_WAIT, DEV_ID2);
      else              rdata <= arr_word;
    end
  end
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYC = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          we,
  input logic [15:0]   wdata,
  input logic          busy,
  input logic          launch,
  input seq_st_t       st,
  input logic          mem_we,
  input logic [15:0]   mem_wdata,
  input logic [15:0]   mem_old
);
  logic [31:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= '0;
  end

  p_launch_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  p_clear_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_wdata & ~mem_old) == 16'h0000));

  p_byp_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BYP_PROG && we && !busy) |=> (st == ST_BYP));

  p_no_launch_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);

  p_state_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(st));

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == 32'(PROG_CYC)));

  p_id_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AUTO && we && !busy && wdata[7:0] != C_RST) |=> (st == ST_AUTO));
endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .wdata(wdata), .busy(busy), .launch(launch),
  .st(st), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_old(mem_old)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
  localparam int PCYC  = 6;
  localparam int WORDS = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] mdl [WORDS];

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.PROG_CYC(PCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] v);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    v = rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic unlock();
    wr(12'h555, 16'h00AA);
    wr(12'h2AA, 16'h0055);
  endtask

  function automatic logic [15:0] pat1(input int i);
    return 16'((i * 16'h3B1D) ^ 16'hC3A5);
  endfunction

  function automatic logic [15:0] pat2(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b, ~b} ^ 16'h0F0F;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] d;
    int n;
    for (int i = 0; i < WORDS; i++) mdl[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 rdata after reset", rdata, 16'h0000);
    chk("R6 busy after reset", {15'b0, busy}, 16'h0000);
    rd(12'h000, v); chk("R2 erased array", v, 16'hFFFF);

    // R8 identification mode
    unlock(); wr(12'h555, 16'h0090);
    rd(12'h000, v); chk("R8 off0", v, 16'h0001);
    rd(12'h001, v); chk("R8 off1", v, 16'h227E);
    rd(12'h002, v); chk("R8 lock sector0", v, 16'h0001);
    rd(12'h042, v); chk("R8 lock sector1", v, 16'h0000);
    rd(12'h082, v); chk("R8 lock sector2", v, 16'h0001);
    rd(12'h003, v); chk("R8 handshake", v, 16'h0043);
    rd(12'h00E, v); chk("R8 offE", v, 16'h2222);
    rd(12'h00F, v); chk("R8 offF", v, 16'h2200);
    rd(12'h007, v); chk("R8 other", v, 16'h0000);
    // R9 non-reset writes keep ID mode
    wr(12'h555, 16'h00AA); wr(12'h000, 16'h0000);
    rd(12'h001, v); chk("R9 still id", v, 16'h227E);
    wr(12'h123, 16'h00F0);
    rd(12'h001, v); chk("R9 back to read", v, 16'hFFFF);

    // R10 broken sequence and mid-sequence reset
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0012);
    wr(12'h555, 16'h00A0); wr(12'h010, 16'h0000);
    chk("R10 broken no busy", {15'b0, busy}, 16'h0000);
    rd(12'h010, v); chk("R10 broken no program", v, 16'hFFFF);
    unlock(); wr(12'h000, 16'h00F0);
    wr(12'h555, 16'h00A0); wr(12'h011, 16'h0000);
    rd(12'h011, v); chk("R10 reset mid sequence", v, 16'hFFFF);

    // R3 bypass programming sweep
    unlock(); wr(12'h555, 16'h0020);
    for (int i = 0; i < WORDS; i++) begin
      wr(12'h000, 16'h00A0);
      wr(12'(i), pat1(i));
      mdl[i] = mdl[i] & pat1(i);
      wait_idle(n);
      if (i % 64 == 0) chk("R6 bypass busy length", 16'(n), 16'(PCYC));
    end
    for (int i = 0; i < WORDS; i++) begin
      rd(12'(i), v); chk("R3 bypass word", v, mdl[i]);
    end

    // R4 bypass exit
    wr(12'h000, 16'h0090); wr(12'h000, 16'h0000);
    wr(12'h000, 16'h00A0); wr(12'h020, 16'h0000);
    chk("R4 exit no busy", {15'b0, busy}, 16'h0000);
    rd(12'h020, v); chk("R4 exit no program", v, mdl[32]);

    // R1/R2 standard program sweep, AND with old contents
    for (int i = 0; i < WORDS; i++) begin
      unlock(); wr(12'h555, 16'h00A0);
      wr(12'(i), pat2(i));
      mdl[i] = mdl[i] & pat2(i);
      if (i % 32 == 0) chk("R1 busy after fourth write", {15'b0, busy}, 16'h0001);
      wait_idle(n);
      if (i % 64 == 0) chk("R6 standard busy length", 16'(n), 16'(PCYC));
    end
    for (int i = 0; i < WORDS; i++) begin
      rd(12'(i), v); chk("R2 and-merged word", v, mdl[i]);
    end

    // R7 status with error flag (data sets a cleared bit)
    d = 16'hFFFF;
    unlock(); wr(12'h555, 16'h00A0); wr(12'h005, d);
    rd(12'h005, v); chk("R7 status read1", v, {8'h00, ~d[7], 1'b0, (mdl[5] != 16'hFFFF), 2'b00, 1'b0, 2'b00});
    rd(12'h005, v); chk("R7 status read2", v, {8'h00, ~d[7], 1'b1, (mdl[5] != 16'hFFFF), 2'b00, 1'b1, 2'b00});
    rd(12'h005, v); chk("R7 status read3", v, {8'h00, ~d[7], 1'b0, (mdl[5] != 16'hFFFF), 2'b00, 1'b0, 2'b00});
    wait_idle(n);
    rd(12'h005, v); chk("R6 read mode after program", v, mdl[5]);

    // R7 status without error, bit7 data 0
    d = mdl[6] & 16'h7F00;
    unlock(); wr(12'h555, 16'h00A0); wr(12'h006, d);
    mdl[6] = mdl[6] & d;
    rd(12'h006, v); chk("R7 status no error", v, 16'h0080);
    rd(12'h006, v); chk("R7 status toggle", v, 16'h00C4);
    wait_idle(n);
    rd(12'h006, v); chk("R2 masked word", v, mdl[6]);

    // R5 writes while busy ignored
    unlock(); wr(12'h555, 16'h00A0); wr(12'h007, 16'h0000);
    mdl[7] = 16'h0000;
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055);
    wr(12'h555, 16'h00A0); wr(12'h008, 16'h0000);
    wait_idle(n);
    chk("R5 busy length unaffected", 16'(n), 16'(PCYC - 4));
    rd(12'h008, v); chk("R5 target untouched", v, mdl[8]);
    wr(12'h555, 16'h00A0); wr(12'h008, 16'h0000);
    rd(12'h008, v); chk("R5 sequence not advanced", v, mdl[8]);
    rd(12'h007, v); chk("R5 program completed", v, 16'h0000);

    // R11 hardware reset aborts
    unlock(); wr(12'h555, 16'h00A0); wr(12'h009, 16'h0000);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 busy cleared", {15'b0, busy}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h009, v); chk("R11 word unchanged", v, mdl[9]);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule